// File: doc/BRIEF.md
# Keyed Oscillator Control Register File

This block is the control register file of a ring-oscillator controller. It sits on an APB-style bus and holds every setting the oscillator needs: on/off, how many delay stages the ring uses, per-stage drive strength, sleep state, output divide ratio and the phase-shifted output controls. The settings leave the block as decoded control signals that the analog side can use directly.

Almost every field is protected by a key or a magic code, which guards against stray writes. A write that does not carry the expected key still lands in the register, and software reads back exactly what it wrote. The decoded output, however, falls back to a defined safe value. The write also raises a sticky error flag that software clears by writing a one. The decoded outputs come straight from the stored words, so a setting takes effect in the cycle after the APB access phase that writes it.

Top module: `osc_ctl_regs`

## Requirements
- R1: After reset the registers read ctrl=0x00000AA0, drive banks=0, sleep word=0x77616B65, divider=0x0000AA20 and phase=0x00000008. In this state the oscillator is enabled, uses 8 stages, all drive levels are 0, the block is awake, the divide ratio is 32, and the phase output is enabled with flip 0 and shift 0.
- R2: The enable code sits in ctrl bits 23:12 at offset 0x00. Code 0xD1E turns osc_en off and 0xFAB turns it on. Any other code turns it on and sets the bad-write flag.
- R3: The range code sits in ctrl bits 11:0. The codes map to stage counts as follows: 0xFA4 gives 8, 0xFA5 gives 6, 0xFA7 gives 4 and 0xFA6 gives 2. Any other code gives 8 and sets the bad-write flag.
- R4: Drive bank A (offset 0x04) covers stages 0–3 and bank B (offset 0x08) covers stages 4–7. Within a bank, stage k uses a 3-bit field at bits 4k+2:4k, and the bank's key sits in bits 31:16. When the key is 0x9696, each stage's level is the number of set bits in its field (0..3). With any other key, all four levels of that bank are 0 and the bad-write flag is set. Stage n drives drive_lvl[2n+1:2n].
- R5: The sleep word at offset 0x0C is 32 bits. 0x636F6D61 asserts dormant and 0x77616B65 deasserts it. Any other word deasserts it and sets the bad-write flag.
- R6: The divider word sits at offset 0x10, bits 15:0. An upper byte of 0xAA with a low byte of 1..127 gives a ratio equal to the low byte, and a low byte of 0 gives 128. A wrong upper byte, or a low byte above 127, gives 128 and sets the bad-write flag.
- R7: The phase word sits at offset 0x14. Its key is bits 11:4, and with key 0xAA, bit 3 is phase_en, bit 2 is phase_flip and bits 1:0 are phase_shift. With any other key the outputs are enable 1, flip 0 and shift 0, and the bad-write flag is set.
- R8: The bad-write flag is status bit 24 at offset 0x18, and it is sticky. Valid writes and status writes with bit 24 clear leave it set. A status write with bit 24 set clears it.
- R9: Status bit 12 reads the live value of osc_en.
- R10: Reads return the stored raw words masked to their implemented bits: ctrl 0x00FFFFFF, drive 0xFFFF7777, sleep 0xFFFFFFFF, divider 0x0000FFFF, phase 0x00000FFF. A read of an unmapped offset, or any read while psel is low, returns 0.
- R11: A register changes only on an access-phase write, that is, with psel, penable and pwrite all high. A setup phase alone, or penable without psel, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | Write when high |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| osc_en | output | 1 | Oscillator enable |
| range_stages | output | 4 | Number of ring stages in use (2, 4, 6 or 8) |
| drive_lvl | output | 16 | Two-bit drive level for each of 8 stages |
| dormant | output | 1 | Oscillator paused |
| div_ratio | output | 8 | Output divide ratio, 1..128 |
| phase_en | output | 1 | Phase-shifted output enable |
| phase_flip | output | 1 | Phase-shifted output inversion |
| phase_shift | output | 2 | Phase shift in input clocks |

## Verification
The bench targets the places where a keyed field is most easily decoded wrong. It exercises:
- each Gray range code, including the out-of-order high and too-high pair, where a swapped decode would report 4 and 2 stages the wrong way round;
- a divider low byte of exactly 0, 127 and 128, where an off-by-one would either accept 128 as a ratio or turn 0 into a zero ratio;
- drive words with a wrong key but non-zero fields, where a design that applied the fields anyway would show non-zero levels;
- drive fields with the unused fourth bit of a nibble set, where a design that counted that bit would produce a level of 4 that wraps.

It also checks that the error flag survives valid writes and zero-valued status writes, and that a setup phase with no access phase leaves the oscillator running.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;

    localparam int DATA_W          = 32;
    localparam int CTRL_W          = 24;
    localparam int CODE_W          = 12;
    localparam int DIV_W           = 16;
    localparam int PHASE_W         = 12;
    localparam int N_BANKS         = 2;
    localparam int STAGES_PER_BANK = 4;
    localparam int N_STAGES        = N_BANKS * STAGES_PER_BANK;
    localparam int FLD_W           = 3;
    localparam int STAGE_PITCH     = 4;
    localparam int LVL_W           = 2;
    localparam int STG_CNT_W       = 4;
    localparam int RATIO_W         = 8;
    localparam int BAD_BIT         = 24;
    localparam int LIVE_EN_BIT     = 12;

    localparam logic [CODE_W-1:0] EN_OFF   = 12'hD1E;
    localparam logic [CODE_W-1:0] EN_ON    = 12'hFAB;
    localparam logic [CODE_W-1:0] RNG_LOW  = 12'hFA4;
    localparam logic [CODE_W-1:0] RNG_MED  = 12'hFA5;
    localparam logic [CODE_W-1:0] RNG_HIGH = 12'hFA7;
    localparam logic [CODE_W-1:0] RNG_MAX  = 12'hFA6;
    localparam logic [15:0]       DRV_KEY  = 16'h9696;
    localparam logic [31:0]       SLEEP_W  = 32'h636F6D61;
    localparam logic [31:0]       WAKE_W   = 32'h77616B65;
    localparam logic [7:0]        DIV_KEY  = 8'hAA;
    localparam logic [7:0]        PH_KEY   = 8'hAA;

    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_DRV0  = 8'h04;
    localparam logic [7:0] OFF_SLEEP = 8'h0C;
    localparam logic [7:0] OFF_DIV   = 8'h10;
    localparam logic [7:0] OFF_PHASE = 8'h14;
    localparam logic [7:0] OFF_STAT  = 8'h18;

    localparam logic [CTRL_W-1:0]  CTRL_RST  = 24'h000AA0;
    localparam logic [DIV_W-1:0]   DIV_RST   = 16'hAA20;
    localparam logic [PHASE_W-1:0] PHASE_RST = 12'h008;
    localparam logic [31:0]        DRV_MASK  = 32'hFFFF7777;

    typedef struct packed {
        logic [CTRL_W-1:0]              ctrl;
        logic [N_BANKS-1:0][DATA_W-1:0] drv;
        logic [DATA_W-1:0]              sleep;
        logic [DIV_W-1:0]               div;
        logic [PHASE_W-1:0]             phase;
        logic                           bad;
    } regs_t;

    function automatic logic en_code_ok(input logic [CODE_W-1:0] c);
        return (c == EN_OFF) || (c == EN_ON);
    endfunction

    function automatic logic rng_code_ok(input logic [CODE_W-1:0] c);
        return (c == RNG_LOW) || (c == RNG_MED) || (c == RNG_HIGH) || (c == RNG_MAX);
    endfunction

    function automatic logic div_word_ok(input logic [DIV_W-1:0] w);
        return (w[15:8] == DIV_KEY) && !w[7];
    endfunction

endpackage

// File: rtl/osc_drive_decode.sv
module osc_drive_decode
    import osc_ctl_pkg::*;
#(
    parameter int STAGES = STAGES_PER_BANK
) (
    input  logic [DATA_W-1:0]       word,
    output logic [STAGES*LVL_W-1:0] lvl
);

    logic key_ok;
    logic unused_word;

    assign key_ok      = (word[31:16] == DRV_KEY);
    assign unused_word = ^word;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [FLD_W-1:0] fld;
        logic [LVL_W-1:0] cnt;

        assign fld = word[s*STAGE_PITCH +: FLD_W];

        always_comb begin
            cnt = '0;
            for (int b = 0; b < FLD_W; b++) begin
                cnt = cnt + LVL_W'(fld[b]);
            end
        end

        assign lvl[s*LVL_W +: LVL_W] = key_ok ? cnt : '0;
    end

endmodule

// File: rtl/osc_mode_decode.sv
module osc_mode_decode
    import osc_ctl_pkg::*;
(
    input  logic [CTRL_W-1:0]    ctrl,
    input  logic [DATA_W-1:0]    sleep,
    input  logic [DIV_W-1:0]     div,
    input  logic [PHASE_W-1:0]   phase,
    output logic                 osc_en,
    output logic [STG_CNT_W-1:0] range_stages,
    output logic                 dormant,
    output logic [RATIO_W-1:0]   div_ratio,
    output logic                 phase_en,
    output logic                 phase_flip,
    output logic [1:0]           phase_shift
);

    localparam logic [RATIO_W-1:0] RATIO_MAX = RATIO_W'(128);

    assign osc_en  = (ctrl[23:12] != EN_OFF);
    assign dormant = (sleep == SLEEP_W);

    always_comb begin
        unique case (ctrl[11:0])
            RNG_MED:  range_stages = STG_CNT_W'(6);
            RNG_HIGH: range_stages = STG_CNT_W'(4);
            RNG_MAX:  range_stages = STG_CNT_W'(2);
            default:  range_stages = STG_CNT_W'(8);
        endcase
    end

    always_comb begin
        if (div_word_ok(div) && (div[6:0] != 7'd0)) begin
            div_ratio = {1'b0, div[6:0]};
        end else begin
            div_ratio = RATIO_MAX;
        end
    end

    always_comb begin
        if (phase[11:4] == PH_KEY) begin
            phase_en    = phase[3];
            phase_flip  = phase[2];
            phase_shift = phase[1:0];
        end else begin
            phase_en    = 1'b1;
            phase_flip  = 1'b0;
            phase_shift = 2'd0;
        end
    end

endmodule

// File: rtl/osc_ctl_regs.sv
module osc_ctl_regs
    import osc_ctl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      psel,
    input  logic                      penable,
    input  logic                      pwrite,
    input  logic [ADDR_W-1:0]         paddr,
    input  logic [DATA_W-1:0]         pwdata,
    output logic [DATA_W-1:0]         prdata,
    output logic                      osc_en,
    output logic [STG_CNT_W-1:0]      range_stages,
    output logic [N_STAGES*LVL_W-1:0] drive_lvl,
    output logic                      dormant,
    output logic [RATIO_W-1:0]        div_ratio,
    output logic                      phase_en,
    output logic                      phase_flip,
    output logic [1:0]                phase_shift
);

    localparam int                BANK_LVL_W = STAGES_PER_BANK * LVL_W;
    localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_SLEEP    = ADDR_W'(OFF_SLEEP);
    localparam logic [ADDR_W-1:0] A_DIV      = ADDR_W'(OFF_DIV);
    localparam logic [ADDR_W-1:0] A_PHASE    = ADDR_W'(OFF_PHASE);
    localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'(OFF_STAT);

    regs_t st_d, st_q;
    logic  wr_en;
    logic  bad_wr_d;

    assign wr_en = psel && penable && pwrite;

    function automatic logic [ADDR_W-1:0] drv_addr(input int b);
        return ADDR_W'(int'(OFF_DRV0) + 4 * b);
    endfunction

    always_comb begin
        st_d     = st_q;
        bad_wr_d = 1'b0;
        if (wr_en) begin
            if (paddr == A_CTRL) begin
                st_d.ctrl = pwdata[CTRL_W-1:0];
                bad_wr_d  = !en_code_ok(pwdata[23:12]) || !rng_code_ok(pwdata[11:0]);
            end
            for (int b = 0; b < N_BANKS; b++) begin
                if (paddr == drv_addr(b)) begin
                    st_d.drv[b] = pwdata & DRV_MASK;
                    bad_wr_d    = (pwdata[31:16] != DRV_KEY);
                end
            end
            if (paddr == A_SLEEP) begin
                st_d.sleep = pwdata;
                bad_wr_d   = (pwdata != SLEEP_W) && (pwdata != WAKE_W);
            end
            if (paddr == A_DIV) begin
                st_d.div = pwdata[DIV_W-1:0];
                bad_wr_d = !div_word_ok(pwdata[DIV_W-1:0]);
            end
            if (paddr == A_PHASE) begin
                st_d.phase = pwdata[PHASE_W-1:0];
                bad_wr_d   = (pwdata[11:4] != PH_KEY);
            end
        end
        st_d.bad = st_q.bad || bad_wr_d;
        if (wr_en && (paddr == A_STAT) && pwdata[BAD_BIT]) begin
            st_d.bad = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl  <= CTRL_RST;
            st_q.drv   <= '0;
            st_q.sleep <= WAKE_W;
            st_q.div   <= DIV_RST;
            st_q.phase <= PHASE_RST;
            st_q.bad   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        osc_drive_decode #(.STAGES(STAGES_PER_BANK)) i_drv (
            .word (st_q.drv[b]),
            .lvl  (drive_lvl[b*BANK_LVL_W +: BANK_LVL_W])
        );
    end

    osc_mode_decode i_mode (
        .ctrl         (st_q.ctrl),
        .sleep        (st_q.sleep),
        .div          (st_q.div),
        .phase        (st_q.phase),
        .osc_en       (osc_en),
        .range_stages (range_stages),
        .dormant      (dormant),
        .div_ratio    (div_ratio),
        .phase_en     (phase_en),
        .phase_flip   (phase_flip),
        .phase_shift  (phase_shift)
    );

    always_comb begin
        prdata = '0;
        if (psel) begin
            if (paddr == A_CTRL)  prdata = DATA_W'(st_q.ctrl);
            if (paddr == A_SLEEP) prdata = st_q.sleep;
            if (paddr == A_DIV)   prdata = DATA_W'(st_q.div);
            if (paddr == A_PHASE) prdata = DATA_W'(st_q.phase);
            if (paddr == A_STAT) begin
                prdata[BAD_BIT]     = st_q.bad;
                prdata[LIVE_EN_BIT] = osc_en;
            end
            for (int b = 0; b < N_BANKS; b++) begin
                if (paddr == drv_addr(b)) prdata = st_q.drv[b];
            end
        end
    end

    AST_BAD_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (paddr == A_CTRL) && !en_code_ok(pwdata[23:12]) |=> st_q.bad); // R2

    AST_STAGES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (range_stages == 4'd2) || (range_stages == 4'd4) ||
        (range_stages == 4'd6) || (range_stages == 4'd8)); // R3

    AST_DRV_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (paddr == drv_addr(0)) && (pwdata[31:16] != DRV_KEY)
        |=> (drive_lvl[BANK_LVL_W-1:0] == '0)); // R4

    AST_SLEEP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (paddr == A_SLEEP) && (pwdata != SLEEP_W) |=> !dormant); // R5

    AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ratio != '0) && (div_ratio <= 8'd128)); // R6

    AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bad && !(wr_en && (paddr == A_STAT) && pwdata[BAD_BIT]) |=> st_q.bad); // R8

    AST_BAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (paddr == A_STAT) && pwdata[BAD_BIT] |=> !st_q.bad); // R8

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q)); // R11

endmodule

// File: tb/test_osc_ctl_regs.sv
`timescale 1ns/1ps
module test_osc_ctl_regs;

    localparam int AW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        osc_en, dormant, phase_en, phase_flip;
    logic [3:0]  range_stages;
    logic [15:0] drive_lvl;
    logic [7:0]  div_ratio;
    logic [1:0]  phase_shift;

    int checks = 0;
    int fails  = 0;
    logic live_on = 1'b0;

    logic [31:0] m_ctrl, m_drv0, m_drv1, m_sleep, m_div, m_phase;
    logic        m_bad;

    always #4 clk = ~clk;

    osc_ctl_regs #(.ADDR_W(AW)) i_osc_ctl_regs (
        .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
        .osc_en, .range_stages, .drive_lvl, .dormant, .div_ratio,
        .phase_en, .phase_flip, .phase_shift
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [3:0] e_stages(input logic [11:0] c);
        case (c)
            12'hFA5: return 4'd6;
            12'hFA7: return 4'd4;
            12'hFA6: return 4'd2;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [15:0] e_drive();
        logic [15:0] r = '0;
        for (int b = 0; b < 2; b++) begin
            logic [31:0] w = (b == 0) ? m_drv0 : m_drv1;
            if (w[31:16] == 16'h9696) begin
                for (int s = 0; s < 4; s++) begin
                    int n = 0;
                    for (int k = 0; k < 3; k++) n += int'(w[4*s+k]);
                    r[(b*4+s)*2 +: 2] = 2'(n);
                end
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] e_ratio();
        if (m_div[15:8] == 8'hAA && m_div[7:0] < 8'd128)
            return (m_div[7:0] == 8'd0) ? 8'd128 : m_div[7:0];
        return 8'd128;
    endfunction

    function automatic logic [3:0] e_phase();
        if (m_phase[11:4] == 8'hAA) return m_phase[3:0];
        return 4'b1000;
    endfunction

    always @(negedge clk) begin
        if (live_on) begin
            chk("R2 osc_en", 32'(osc_en), 32'(m_ctrl[23:12] != 12'hD1E));
            chk("R3 range_stages", 32'(range_stages), 32'(e_stages(m_ctrl[11:0])));
            chk("R4 drive_lvl", 32'(drive_lvl), 32'(e_drive()));
            chk("R5 dormant", 32'(dormant), 32'(m_sleep == 32'h636F6D61));
            chk("R6 div_ratio", 32'(div_ratio), 32'(e_ratio()));
            chk("R7 phase", 32'({phase_en, phase_flip, phase_shift}), 32'(e_phase()));
        end
    end

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h00: begin
                m_ctrl = d & 32'h00FFFFFF;
                if (!(d[23:12] inside {12'hD1E, 12'hFAB}) ||
                    !(d[11:0] inside {12'hFA4, 12'hFA5, 12'hFA6, 12'hFA7})) m_bad = 1'b1;
            end
            8'h04, 8'h08: begin
                if (a == 8'h04) m_drv0 = d & 32'hFFFF7777;
                else            m_drv1 = d & 32'hFFFF7777;
                if (d[31:16] != 16'h9696) m_bad = 1'b1;
            end
            8'h0C: begin
                m_sleep = d;
                if (d != 32'h636F6D61 && d != 32'h77616B65) m_bad = 1'b1;
            end
            8'h10: begin
                m_div = d & 32'h0000FFFF;
                if (d[15:8] != 8'hAA || d[7]) m_bad = 1'b1;
            end
            8'h14: begin
                m_phase = d & 32'h00000FFF;
                if (d[11:4] != 8'hAA) m_bad = 1'b1;
            end
            8'h18: if (d[24]) m_bad = 1'b0;
            default: ;
        endcase
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = AW'(a); pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = AW'(a);
        @(negedge clk);
        penable = 1'b1;
        #1 chk(req, prdata, exp);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [31:0] stat_exp();
        return (32'(m_bad) << 24) | (32'(m_ctrl[23:12] != 12'hD1E) << 12);
    endfunction

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_ctrl = 32'h00000AA0; m_drv0 = '0; m_drv1 = '0; m_sleep = 32'h77616B65;
        m_div = 32'h0000AA20; m_phase = 32'h00000008; m_bad = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live_on = 1'b1;
        // R1 reset values, R9 live enable in status
        rd("R1 ctrl", 8'h00, 32'h00000AA0);
        rd("R1 drvA", 8'h04, 32'h0);
        rd("R1 drvB", 8'h08, 32'h0);
        rd("R1 sleep", 8'h0C, 32'h77616B65);
        rd("R1 div", 8'h10, 32'h0000AA20);
        rd("R1 phase", 8'h14, 32'h00000008);
        rd("R1 R9 status", 8'h18, 32'h00001000);
        chk("R1 div_ratio", 32'(div_ratio), 32'd32);
        // R2 R3 valid codes
        wr(8'h00, {8'h0, 12'hD1E, 12'hFA5});
        rd("R9 status disabled", 8'h18, stat_exp());
        wr(8'h00, {8'h0, 12'hFAB, 12'hFA7});
        wr(8'h00, {8'h0, 12'hFAB, 12'hFA6});
        wr(8'h00, {8'h0, 12'hFAB, 12'hFA4});
        rd("R8 no bad after valid", 8'h18, stat_exp());
        // R2 invalid enable code
        wr(8'h00, {8'h0, 12'h123, 12'hFA5});
        rd("R2 bad set", 8'h18, 32'h01001000);
        // R8 sticky
        wr(8'h18, 32'h0);
        rd("R8 zero write keeps", 8'h18, stat_exp());
        wr(8'h10, 32'h0000AA05);
        rd("R8 valid write keeps", 8'h18, stat_exp());
        wr(8'h18, 32'h01000000);
        rd("R8 cleared", 8'h18, stat_exp());
        // R3 invalid range
        wr(8'h00, {8'hFF, 12'hD1E, 12'h555});
        rd("R3 bad range", 8'h18, stat_exp());
        rd("R10 ctrl raw", 8'h00, 32'h00D1E555);
        wr(8'h18, 32'hFFFFFFFF);
        wr(8'h00, {8'h0, 12'hFAB, 12'hFA4});
        // R4 drive banks
        wr(8'h04, 32'h96967531);
        wr(8'h04, 32'h9696F8FF);
        rd("R10 drvA mask", 8'h04, 32'h96967077);
        wr(8'h08, 32'h12347777);
        rd("R4 bad key", 8'h18, stat_exp());
        rd("R10 drvB raw", 8'h08, 32'h12347777);
        wr(8'h08, 32'h96960246);
        wr(8'h18, 32'h01000000);
        // R5 sleep
        wr(8'h0C, 32'h636F6D61);
        chk("R5 dormant", 32'(dormant), 32'd1);
        wr(8'h0C, 32'h77616B65);
        wr(8'h0C, 32'h636F6D61);
        wr(8'h0C, 32'hDEADBEEF);
        rd("R5 bad sleep", 8'h18, stat_exp());
        wr(8'h18, 32'h01000000);
        // R6 divider
        wr(8'h10, 32'h0000AA00);
        wr(8'h10, 32'h0000AA01);
        wr(8'h10, 32'h0000AA7F);
        rd("R6 no bad at 127", 8'h18, stat_exp());
        wr(8'h10, 32'h0000AA80);
        wr(8'h10, 32'h0000BB10);
        rd("R10 div raw", 8'h10, 32'h0000BB10);
        wr(8'h10, 32'h1234AA10);
        rd("R10 div mask", 8'h10, 32'h0000AA10);
        wr(8'h18, 32'h01000000);
        // R7 phase
        wr(8'h14, 32'h00000AAF);
        wr(8'h14, 32'h00000AA2);
        rd("R7 no bad", 8'h18, stat_exp());
        wr(8'h14, 32'h0000055F);
        rd("R7 bad key", 8'h18, stat_exp());
        wr(8'h18, 32'h01000000);
        // R11 setup only, then penable without psel
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = '0; pwdata = {8'h0, 12'hD1E, 12'hFA6};
        @(negedge clk);
        psel = 1'b0; penable = 1'b1;
        @(negedge clk);
        penable = 1'b0; pwrite = 1'b0;
        rd("R11 ctrl unchanged", 8'h00, m_ctrl);
        chk("R11 osc_en held", 32'(osc_en), 32'd1);
        // R10 unmapped and unselected
        rd("R10 unmapped", 8'h1C, 32'h0);
        @(negedge clk);
        paddr = '0;
        #1 chk("R10 psel low", prdata, 32'h0);
        repeat (4) @(negedge clk);
        live_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule